// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multi-register load or store request into a stream of single-word transfer beats. A request is a 32-bit base pointer, a 16-bit mask naming which registers take part, and five control flags: direction (load or store), pre- or post-adjustment, increment or decrement, write-back enable, and a privileged-transfer flag. All of them are captured on a one-cycle start strobe while the block is idle.

For every register named in the mask the block presents one beat on a valid/ready output. Each beat carries the register index, the word address and the load/store direction, plus the privileged flag, which is forwarded unchanged. Registers are visited from the lowest index upward, and the lowest index always gets the lowest address, so the four indexing modes differ only in where the address window starts. Stack pushes and pops are the same four modes under other names: a push onto a full, descending stack is a pre-decrement store, and the matching pop is a post-increment load. When the last beat is accepted the block raises a one-cycle done pulse. With that pulse it shows the base pointer after adjustment and says whether that value is to be written back.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset, busy_o, beat_valid_o, done_o and wb_en_o are all 0.
- R2: One beat is issued for each set bit of the captured mask. Beat register indices (beat_reg_o, 4 bits, value = bit position) rise strictly from the lowest set bit to the highest.
- R3: With n set bits, the first beat address is base+4 for pre-increment (pre_i=1, up_i=1), base for post-increment (0,1), base-4n for pre-decrement (1,0) and base-4n+4 for post-decrement (0,0). Each later beat is 4 higher. Arithmetic wraps modulo 2^32.
- R4: The done cycle shows wb_value_o = base+4n when up_i=1 and base-4n when up_i=0. wb_en_o equals the captured wb_i in that cycle and is 0 in every other cycle.
- R5: beat_load_o equals the captured load_i (1 = load, 0 = store) on every beat. beat_psr_o equals the captured psr_i on every beat.
- R6: While beat_valid_o=1 and beat_ready_i=0, the next cycle still has beat_valid_o=1 with the same register index, address and flags.
- R7: If the captured mask is all zero, no beat is issued and done_o is 1 in the cycle right after the start strobe.
- R8: done_o is a single-cycle pulse in the cycle after the last beat handshake. busy_o is 0 in the cycle after done_o.
- R9: A start strobe while busy_o=1 is ignored: the running sequence's beats, write-back value and length are unchanged.
- R10: Stack forms: a full-descending push (load_i=0, pre_i=1, up_i=0) puts its highest register at base-4 and writes back base-4n. A full-descending pop (load_i=1, pre_i=0, up_i=1) reads its lowest register at base and writes back base+4n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| base_i | input | 32 | Base pointer |
| mask_i | input | 16 | Register selection, bit k = register k |
| load_i | input | 1 | 1 = load, 0 = store |
| pre_i | input | 1 | 1 = adjust before access |
| up_i | input | 1 | 1 = increment, 0 = decrement |
| wb_i | input | 1 | Write-back request |
| psr_i | input | 1 | Privileged flag, forwarded on beats |
| busy_o | output | 1 | Request in progress |
| beat_valid_o | output | 1 | Beat presented |
| beat_ready_i | input | 1 | Beat accepted by consumer |
| beat_reg_o | output | 4 | Register index of the beat |
| beat_addr_o | output | 32 | Word address of the beat |
| beat_load_o | output | 1 | Direction of the beat |
| beat_psr_o | output | 1 | Forwarded privileged flag |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Write-back enable, only with done_o |
| wb_value_o | output | 32 | Adjusted base pointer, valid with done_o |

## Verification
Two things can land on the same clock edge: the handshake of the final beat, and a new start strobe arriving while the sequence is still busy. The bench drives start strobes, carrying unrelated base and mask values, on random cycles during runs, including the cycle that accepts the final beat. It then checks that the beats, the done cycle and the write-back value still match the request that was captured first, and that the block is idle again one cycle after done. Random back-pressure is applied throughout, so that held beats and that collision are both exercised under stall.

// File: rtl/bx_pkg.sv
package bx_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_DONE = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic load;
        logic wben;
        logic psr;
    } sq_flags_t;
endpackage

// File: rtl/bx_popcnt.sv
module bx_popcnt #(
    parameter int W  = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < W; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
        end
    end
endmodule

// File: rtl/bx_lowpick.sv
module bx_lowpick #(
    parameter int W  = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic [W-1:0]  rest_o
);
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
        rest_o = vec_i & (vec_i - W'(1));
    end
endmodule

// File: rtl/bx_span_calc.sv
module bx_span_calc #(
    parameter int AW         = 32,
    parameter int CW         = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          pre_i,
    input  logic          up_i,
    output logic [AW-1:0] first_o,
    output logic [AW-1:0] final_o
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [AW-1:0] span;
    logic [AW-1:0] low_end;

    always_comb begin
        span    = AW'(cnt_i) * STEP;
        low_end = base_i - span;
        if (up_i) begin
            final_o = base_i + span;
            first_o = pre_i ? base_i + STEP : base_i;
        end else begin
            final_o = low_end;
            first_o = pre_i ? low_end : low_end + STEP;
        end
    end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import bx_pkg::*;
#(
    parameter int AW         = 32,
    parameter int REGS       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IW        = $clog2(REGS),
    localparam int CW        = $clog2(REGS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    input  logic [REGS-1:0] mask_i,
    input  logic          load_i,
    input  logic          pre_i,
    input  logic          up_i,
    input  logic          wb_i,
    input  logic          psr_i,
    output logic          busy_o,
    output logic          beat_valid_o,
    input  logic          beat_ready_i,
    output logic [IW-1:0] beat_reg_o,
    output logic [AW-1:0] beat_addr_o,
    output logic          beat_load_o,
    output logic          beat_psr_o,
    output logic          done_o,
    output logic          wb_en_o,
    output logic [AW-1:0] wb_value_o
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    typedef struct packed {
        sq_state_e     st;
        logic [REGS-1:0] mask;
        logic [AW-1:0] addr;
        logic [AW-1:0] wbv;
        sq_flags_t     fl;
    } sq_regs_t;

    sq_regs_t s_d, s_q;

    logic [CW-1:0]   sel_cnt;
    logic [AW-1:0]   first_addr;
    logic [AW-1:0]   final_base;
    logic [IW-1:0]   cur_idx;
    logic [REGS-1:0] rest_mask;

    bx_popcnt #(.W(REGS)) u_cnt (
        .vec_i (mask_i),
        .cnt_o (sel_cnt)
    );

    bx_span_calc #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_span (
        .base_i  (base_i),
        .cnt_i   (sel_cnt),
        .pre_i   (pre_i),
        .up_i    (up_i),
        .first_o (first_addr),
        .final_o (final_base)
    );

    bx_lowpick #(.W(REGS)) u_pick (
        .vec_i  (s_q.mask),
        .idx_o  (cur_idx),
        .rest_o (rest_mask)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    s_d.mask    = mask_i;
                    s_d.addr    = first_addr;
                    s_d.wbv     = final_base;
                    s_d.fl.load = load_i;
                    s_d.fl.wben = wb_i;
                    s_d.fl.psr  = psr_i;
                    s_d.st      = (mask_i == '0) ? SQ_DONE : SQ_RUN;
                end
            end
            SQ_RUN: begin
                if (beat_ready_i) begin
                    s_d.mask = rest_mask;
                    s_d.addr = s_q.addr + STEP;
                    if (rest_mask == '0) s_d.st = SQ_DONE;
                end
            end
            SQ_DONE: begin
                s_d.st = SQ_IDLE;
            end
            default: begin
                s_d.st = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SQ_IDLE, mask: '0, addr: '0, wbv: '0, fl: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o       = (s_q.st != SQ_IDLE);
    assign beat_valid_o = (s_q.st == SQ_RUN);
    assign beat_reg_o   = cur_idx;
    assign beat_addr_o  = s_q.addr;
    assign beat_load_o  = s_q.fl.load;
    assign beat_psr_o   = s_q.fl.psr;
    assign done_o       = (s_q.st == SQ_DONE);
    assign wb_en_o      = (s_q.st == SQ_DONE) && s_q.fl.wben;
    assign wb_value_o   = s_q.wbv;
endmodule

// File: rtl/bx_seq_chk.sv
module bx_seq_chk #(
    parameter int AW   = 32,
    parameter int REGS = 16,
    parameter int IW   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [REGS-1:0] mask_i,
    input logic            busy_o,
    input logic            beat_valid_o,
    input logic            beat_ready_i,
    input logic [IW-1:0]   beat_reg_o,
    input logic [AW-1:0]   beat_addr_o,
    input logic            beat_load_o,
    input logic            beat_psr_o,
    input logic            done_o,
    input logic            wb_en_o
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!beat_valid_o && !done_o));

    p_reg_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && beat_ready_i) |=> (!beat_valid_o || (beat_reg_o > $past(beat_reg_o))));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && beat_ready_i) |=> (!beat_valid_o || (beat_addr_o == $past(beat_addr_o) + AW'(4))));

    p_wben_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> done_o);

    p_flags_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && $past(beat_valid_o)) |-> ($stable(beat_load_o) && $stable(beat_psr_o)));

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && !beat_ready_i) |=> (beat_valid_o && $stable(beat_reg_o) && $stable(beat_addr_o)));

    p_empty_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (mask_i == '0)) |=> done_o);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
endmodule

bind blkxfer_seq bx_seq_chk #(.AW(AW), .REGS(REGS), .IW(IW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mask_i       (mask_i),
    .busy_o       (busy_o),
    .beat_valid_o (beat_valid_o),
    .beat_ready_i (beat_ready_i),
    .beat_reg_o   (beat_reg_o),
    .beat_addr_o  (beat_addr_o),
    .beat_load_o  (beat_load_o),
    .beat_psr_o   (beat_psr_o),
    .done_o       (done_o),
    .wb_en_o      (wb_en_o)
);

// File: tb/sim_blkxfer_seq.sv
`timescale 1ns/1ps
module sim_blkxfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] mask_i = '0;
    logic        load_i = 1'b0, pre_i = 1'b0, up_i = 1'b0, wb_i = 1'b0, psr_i = 1'b0;
    logic        beat_ready_i = 1'b0;
    logic        busy_o, beat_valid_o, beat_load_o, beat_psr_o, done_o, wb_en_o;
    logic [3:0]  beat_reg_o;
    logic [31:0] beat_addr_o, wb_value_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] g_first, g_last, g_wb;

    always #2.5 clk = ~clk;

    blkxfer_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .mask_i(mask_i),
        .load_i(load_i), .pre_i(pre_i), .up_i(up_i), .wb_i(wb_i), .psr_i(psr_i),
        .busy_o(busy_o), .beat_valid_o(beat_valid_o), .beat_ready_i(beat_ready_i),
        .beat_reg_o(beat_reg_o), .beat_addr_o(beat_addr_o), .beat_load_o(beat_load_o),
        .beat_psr_o(beat_psr_o), .done_o(done_o), .wb_en_o(wb_en_o), .wb_value_o(wb_value_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nbits(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic logic [31:0] exp_first(input logic [31:0] b, input int n, input bit p, input bit u);
        logic [31:0] span = 32'(n) * 32'd4;
        if (u) return p ? b + 32'd4 : b;
        return p ? b - span : b - span + 32'd4;
    endfunction

    function automatic logic [31:0] exp_wb(input logic [31:0] b, input int n, input bit u);
        return u ? b + 32'(n) * 32'd4 : b - 32'(n) * 32'd4;
    endfunction

    task automatic run_op(input logic [31:0] b, input logic [15:0] m, input bit l, input bit p,
                          input bit u, input bit w, input bit s, input int ready_pct, input bit inject);
        int n = nbits(m);
        int k = 0;
        int bitpos = 0;
        logic [31:0] a0 = exp_first(b, n, p, u);
        logic [31:0] ew = exp_wb(b, n, u);
        @(negedge clk);
        start_i = 1'b1; base_i = b; mask_i = m;
        load_i = l; pre_i = p; up_i = u; wb_i = w; psr_i = s;
        @(negedge clk);
        start_i = 1'b0;
        g_first = 'x; g_last = 'x;
        if (m == '0) check(done_o == 1'b1, "R7 done one cycle after empty start", 32'(done_o), 32'd1);
        for (int guard = 0; guard < 2000; guard++) begin
            if (done_o) break;
            check(beat_valid_o == 1'b1, "R2 beat valid while running", 32'(beat_valid_o), 32'd1);
            while (bitpos < 16 && !m[bitpos]) bitpos++;
            check(32'(beat_reg_o) == 32'(bitpos), "R2 register order", 32'(beat_reg_o), 32'(bitpos));
            check(beat_addr_o == a0 + 32'(k) * 32'd4, "R3 beat address", beat_addr_o, a0 + 32'(k) * 32'd4);
            check(beat_load_o == l && beat_psr_o == s, "R5 beat flags",
                  {30'd0, beat_load_o, beat_psr_o}, {30'd0, l, s});
            if (k == 0) g_first = beat_addr_o;
            g_last = beat_addr_o;
            beat_ready_i = ($urandom_range(99) < ready_pct);
            if (inject && ($urandom_range(3) == 0)) begin
                start_i = 1'b1; base_i = $urandom; mask_i = 16'(~m);
                up_i = ~u; pre_i = ~p; load_i = ~l; wb_i = ~w; psr_i = ~s;
            end else begin
                start_i = 1'b0;
            end
            if (!beat_ready_i) begin
                @(negedge clk);
                check(beat_valid_o && beat_addr_o == g_last, "R6 held under stall", beat_addr_o, g_last);
            end else begin
                k++; bitpos++;
                @(negedge clk);
            end
        end
        start_i = 1'b0; beat_ready_i = 1'b0;
        check(done_o == 1'b1, "R8 done reached", 32'(done_o), 32'd1);
        check(k == n, "R2 beat count", 32'(k), 32'(n));
        check(wb_value_o == ew, "R4 write-back value", wb_value_o, ew);
        check(wb_en_o == w, "R4 write-back enable", 32'(wb_en_o), 32'(w));
        g_wb = wb_value_o;
        @(negedge clk);
        check(!done_o && !busy_o && !wb_en_o, "R8 R9 single pulse then idle",
              {29'd0, done_o, busy_o, wb_en_o}, 32'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!busy_o && !beat_valid_o && !done_o && !wb_en_o, "R1 reset state",
              {28'd0, busy_o, beat_valid_o, done_o, wb_en_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !beat_valid_o, "R1 idle after reset", {30'd0, busy_o, beat_valid_o}, 32'd0);

        // R10 full-descending push then pop
        run_op(32'h0000_1000, 16'h0013, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 100, 1'b0);
        check(g_last == 32'h0000_0FFC, "R10 push top at base-4", g_last, 32'h0000_0FFC);
        check(g_wb == 32'h0000_0FF4, "R10 push write-back", g_wb, 32'h0000_0FF4);
        run_op(32'h0000_0FF4, 16'h0013, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 100, 1'b0);
        check(g_first == 32'h0000_0FF4, "R10 pop lowest at base", g_first, 32'h0000_0FF4);
        check(g_wb == 32'h0000_1000, "R10 pop write-back", g_wb, 32'h0000_1000);

        // R7 empty mask, R3 all four modes on full mask with wrap, R9 injections
        run_op(32'h0000_2000, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 100, 1'b0);
        for (int md = 0; md < 4; md++)
            run_op(32'h0000_0008, 16'hFFFF, md[0], md[1], md[0], 1'b1, 1'b1, 60, 1'b1);
        run_op(32'hFFFF_FFF0, 16'h8000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 30, 1'b1);

        for (int t = 0; t < 300; t++) begin
            logic [15:0] m = ($urandom_range(9) == 0) ? 16'h0 : 16'($urandom);
            run_op({$urandom} & 32'hFFFF_FFFC, m, 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom), 20 + $urandom_range(80), 1'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule